// File: doc/BRIEF.md
# Floating-Point Pipeline Structural Hazard Tracker

This block sits next to the issue stage of a dual-issue core and tells it whether a floating-point or integer-multiply operation can start in the current cycle without colliding with work already in flight. It tracks six shared resources: four floating-point pipeline stages (FA, FB, FC, FD) and two integer multiplier stages (MA, MB). Each operation class occupies a fixed, multi-cycle pattern of these resources. The block holds the committed future occupancy in a shift-register table with one row per future cycle.

A request is granted in the same cycle when its whole pattern, laid over the table, overlaps no reserved resource. A further rule forbids any multiplier stage from being busy in a cycle in which FB is reserved. A granted request merges its pattern into the table. A refused request raises `busy_o`, leaves the table untouched, and is expected to be presented again in the next cycle. An integer multiply may run its three-cycle middle section on either multiplier stage. The block tries stage MB first and falls back to MA.

Top module: `fpu_hazard_rsv`

## Requirements
- R1: After reset, `resv_now_o` is all zero and the next request of any class is granted.
- R2: `grant_o` is high exactly when `req_valid_i` is high and the request has no conflict. `busy_o` is high exactly when `req_valid_i` is high and there is a conflict. Both outputs are low when `req_valid_i` is low. Both outputs are combinational in the current cycle.
- R3: A refused request changes no row of the table. Every later `resv_now_o` value is the same as it would be had the request never been made.
- R4: Op code 0 (single arithmetic) reserves FA+FB one cycle after issue and FC two cycles after issue. Op code 2 (double conversion) reserves FA+FB at +1, FB+FC at +2 and FC at +3.
- R5: Op code 1 (single divide) reserves FA+FB+FD at +1, FC+FD at +2, FD alone at +3 through +9, FB+FD at +10 and FC at +11.
- R6: Op code 3 (double arithmetic) reserves FA+FB at +1, FB+FC at +2 through +6, and FC at +7.
- R7: Op code 4 (double divide) reserves FA+FB+FD at +1, FB+FC+FD at +2, FC+FD at +3, FD at +4 through +19, FB+FD at +20, FB+FC+FD at +21 and +22, and FC at +23.
- R8: Op code 5 (integer multiply) reserves MA at +1, one multiplier stage at +2 through +4, and FC at +5. The stage for +2 through +4 is MB if that is conflict-free, and otherwise MA.
- R9: A request is refused if granting it would place MA or MB in the same cycle as FB. `resv_now_o` never shows FB together with MA or MB.
- R10: Op code 6 (status-register load) reserves FB at +2, +3 and +4.
- R11: Op code 7 reserves nothing and is always granted.
- R12: The table advances one row every clock. `resv_now_o` shows the resources in use in the current cycle, with bit 0 FA, bit 1 FB, bit 2 FC, bit 3 FD, bit 4 MA and bit 5 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A candidate operation is presented |
| req_op_i | input | 3 | Operation class code (0 to 7, see requirements) |
| grant_o | output | 1 | The operation may start this cycle; its pattern is committed |
| busy_o | output | 1 | The operation conflicts; retry next cycle |
| resv_now_o | output | 6 | Resources reserved for the current cycle |

## Verification
Two functions of the block meet in a single cycle. The direct-overlap test and the FB-versus-multiplier exclusion are evaluated together with the choice of multiplier stage, and all of them must agree before one pattern is committed. A directed sequence issues a status-register load and then a multiply one cycle later, so that only the exclusion rule can refuse it. It also issues two back-to-back multiplies, which forces the fall-back stage. Random traffic then builds dense overlaps. Each cycle, the grant decision, the busy flag and the current-cycle occupancy are compared with a bench model that keeps its own copy of the table.

// File: rtl/fpu_rsv_pkg.sv
package fpu_rsv_pkg;

  localparam int unsigned NRES = 6;

  // resource bit positions
  localparam int unsigned B_FA = 0;
  localparam int unsigned B_FB = 1;
  localparam int unsigned B_FC = 2;
  localparam int unsigned B_FD = 3;
  localparam int unsigned B_MA = 4;
  localparam int unsigned B_MB = 5;

  typedef logic [NRES-1:0] res_t;

  typedef enum logic [2:0] {
    OP_SARITH = 3'd0,
    OP_SDIV   = 3'd1,
    OP_DCONV  = 3'd2,
    OP_DARITH = 3'd3,
    OP_DDIV   = 3'd4,
    OP_IMUL   = 3'd5,
    OP_STLD   = 3'd6,
    OP_NONE   = 3'd7
  } op_e;

  // longest pattern ends at this offset after issue
  localparam int unsigned LAST_OFS = 23;

  function automatic res_t mk(input logic fa, input logic fb, input logic fc,
                              input logic fd, input logic ma, input logic mb);
    res_t r;
    r = '0;
    r[B_FA] = fa;
    r[B_FB] = fb;
    r[B_FC] = fc;
    r[B_FD] = fd;
    r[B_MA] = ma;
    r[B_MB] = mb;
    return r;
  endfunction

  // occupancy of op at offset ofs after issue; alt_ma selects MA for the mul window
  function automatic res_t op_row(input op_e op, input int unsigned ofs, input logic alt_ma);
    res_t r;
    r = '0;
    unique case (op)
      OP_SARITH: begin
        if (ofs == 1) r = mk(1, 1, 0, 0, 0, 0);
        else if (ofs == 2) r = mk(0, 0, 1, 0, 0, 0);
      end
      OP_SDIV: begin
        if (ofs == 1) r = mk(1, 1, 0, 1, 0, 0);
        else if (ofs == 2) r = mk(0, 0, 1, 1, 0, 0);
        else if (ofs >= 3 && ofs <= 9) r = mk(0, 0, 0, 1, 0, 0);
        else if (ofs == 10) r = mk(0, 1, 0, 1, 0, 0);
        else if (ofs == 11) r = mk(0, 0, 1, 0, 0, 0);
      end
      OP_DCONV: begin
        if (ofs == 1) r = mk(1, 1, 0, 0, 0, 0);
        else if (ofs == 2) r = mk(0, 1, 1, 0, 0, 0);
        else if (ofs == 3) r = mk(0, 0, 1, 0, 0, 0);
      end
      OP_DARITH: begin
        if (ofs == 1) r = mk(1, 1, 0, 0, 0, 0);
        else if (ofs >= 2 && ofs <= 6) r = mk(0, 1, 1, 0, 0, 0);
        else if (ofs == 7) r = mk(0, 0, 1, 0, 0, 0);
      end
      OP_DDIV: begin
        if (ofs == 1) r = mk(1, 1, 0, 1, 0, 0);
        else if (ofs == 2) r = mk(0, 1, 1, 1, 0, 0);
        else if (ofs == 3) r = mk(0, 0, 1, 1, 0, 0);
        else if (ofs >= 4 && ofs <= 19) r = mk(0, 0, 0, 1, 0, 0);
        else if (ofs == 20) r = mk(0, 1, 0, 1, 0, 0);
        else if (ofs == 21 || ofs == 22) r = mk(0, 1, 1, 1, 0, 0);
        else if (ofs == 23) r = mk(0, 0, 1, 0, 0, 0);
      end
      OP_IMUL: begin
        if (ofs == 1) r = mk(0, 0, 0, 0, 1, 0);
        else if (ofs >= 2 && ofs <= 4) r = mk(0, 0, 0, 0, alt_ma, !alt_ma);
        else if (ofs == 5) r = mk(0, 0, 1, 0, 0, 0);
      end
      OP_STLD: begin
        if (ofs >= 2 && ofs <= 4) r = mk(0, 1, 0, 0, 0, 0);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpu_rsv_pattern.sv
module fpu_rsv_pattern
  import fpu_rsv_pkg::*;
#(
  parameter int unsigned DEPTH  = 24,
  parameter bit          ALT_MA = 1'b0
) (
  input  logic [2:0]             op_i,
  output logic [DEPTH-1:0][NRES-1:0] pat_o
);

  op_e op;
  assign op = op_e'(op_i);

  for (genvar k = 0; k < DEPTH; k++) begin : g_row
    assign pat_o[k] = op_row(op, k, ALT_MA);
  end

endmodule

// File: rtl/fpu_rsv_conflict.sv
module fpu_rsv_conflict
  import fpu_rsv_pkg::*;
#(
  parameter int unsigned DEPTH = 24
) (
  input  logic [DEPTH-1:0][NRES-1:0] tab_i,
  input  logic [DEPTH-1:0][NRES-1:0] pat_i,
  output logic                       hit_o
);

  logic [DEPTH-1:0] row_hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_row
    logic overlap, excl;
    assign overlap = |(tab_i[k] & pat_i[k]);
    // FB and any multiplier stage may not share a cycle
    assign excl = (pat_i[k][B_FB] & (tab_i[k][B_MA] | tab_i[k][B_MB]))
                | ((pat_i[k][B_MA] | pat_i[k][B_MB]) & tab_i[k][B_FB]);
    assign row_hit[k] = overlap | excl;
  end

  assign hit_o = |row_hit;

endmodule

// File: rtl/fpu_rsv_table.sv
module fpu_rsv_table
  import fpu_rsv_pkg::*;
#(
  parameter int unsigned DEPTH = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [DEPTH-1:0][NRES-1:0] pat_i,
  output logic [DEPTH-1:0][NRES-1:0] tab_o
);

  logic [DEPTH-1:0][NRES-1:0] tab_q, tab_d;

  for (genvar k = 0; k < DEPTH; k++) begin : g_row
    if (k == DEPTH - 1) begin : g_tail
      assign tab_d[k] = '0;
    end else begin : g_body
      assign tab_d[k] = tab_q[k+1] | (load_i ? pat_i[k+1] : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tab_q <= '0;
    else         tab_q <= tab_d;
  end

  assign tab_o = tab_q;

endmodule

// File: rtl/fpu_hazard_rsv.sv
module fpu_hazard_rsv
  import fpu_rsv_pkg::*;
#(
  parameter int unsigned DEPTH = LAST_OFS + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_op_i,
  output logic       grant_o,
  output logic       busy_o,
  output logic [5:0] resv_now_o
);

  localparam int unsigned NVAR = 2;

  logic [DEPTH-1:0][NRES-1:0] tab;
  logic [DEPTH-1:0][NRES-1:0] pat   [NVAR];
  logic [NVAR-1:0]            hit;
  logic [DEPTH-1:0][NRES-1:0] pat_sel;
  logic                       ok;

  // variant 0: mul window on MB, variant 1: on MA
  for (genvar v = 0; v < NVAR; v++) begin : g_var
    fpu_rsv_pattern #(.DEPTH(DEPTH), .ALT_MA(v == 1)) u_pat (
      .op_i (req_op_i),
      .pat_o(pat[v])
    );
    fpu_rsv_conflict #(.DEPTH(DEPTH)) u_cfl (
      .tab_i(tab),
      .pat_i(pat[v]),
      .hit_o(hit[v])
    );
  end

  assign ok      = !hit[0] || !hit[1];
  assign pat_sel = hit[0] ? pat[1] : pat[0];
  assign grant_o = req_valid_i && ok;
  assign busy_o  = req_valid_i && !ok;

  fpu_rsv_table #(.DEPTH(DEPTH)) u_tab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(grant_o),
    .pat_i (pat_sel),
    .tab_o (tab)
  );

  assign resv_now_o = tab[0];

endmodule

// File: rtl/fpu_hazard_rsv_chk.sv
module fpu_hazard_rsv_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [2:0] req_op_i,
  input logic       grant_o,
  input logic       busy_o,
  input logic [5:0] resv_now_o
);

  assert_grant_busy_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && busy_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!grant_o && !busy_o));

  assert_fb_mul_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resv_now_o[1] && (resv_now_o[4] || resv_now_o[5])));

  assert_fa_follows_grant_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv_now_o[0] |-> $past(grant_o));

  assert_sarith_next_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && req_op_i == 3'd0) |=> (resv_now_o[0] && resv_now_o[1]));

  assert_none_granted_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd7) |-> grant_o);

  assert_ddiv_fd_next_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && req_op_i == 3'd4) |=> resv_now_o[3]);

endmodule

bind fpu_hazard_rsv fpu_hazard_rsv_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_op_i   (req_op_i),
  .grant_o    (grant_o),
  .busy_o     (busy_o),
  .resv_now_o (resv_now_o)
);

// File: tb/fpu_hazard_rsv_tb.sv
module fpu_hazard_rsv_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TD = 24;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [2:0] req_op_i = 3'd0;
  logic       grant_o, busy_o;
  logic [5:0] resv_now_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] m_tab [TD+1];

  fpu_hazard_rsv u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .grant_o(grant_o), .busy_o(busy_o), .resv_now_o(resv_now_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // bits: 1 FA, 2 FB, 4 FC, 8 FD, 16 MA, 32 MB
  function automatic logic [5:0] bm_row(int op, int k, bit alt);
    case (op)
      0: return (k == 1) ? 6'd3 : (k == 2) ? 6'd4 : 6'd0;
      1: begin
        if (k == 1) return 6'd11;
        if (k == 2) return 6'd12;
        if (k >= 3 && k <= 9) return 6'd8;
        if (k == 10) return 6'd10;
        if (k == 11) return 6'd4;
        return 6'd0;
      end
      2: return (k == 1) ? 6'd3 : (k == 2) ? 6'd6 : (k == 3) ? 6'd4 : 6'd0;
      3: begin
        if (k == 1) return 6'd3;
        if (k >= 2 && k <= 6) return 6'd6;
        if (k == 7) return 6'd4;
        return 6'd0;
      end
      4: begin
        if (k == 1) return 6'd11;
        if (k == 2) return 6'd14;
        if (k == 3) return 6'd12;
        if (k >= 4 && k <= 19) return 6'd8;
        if (k == 20) return 6'd10;
        if (k == 21 || k == 22) return 6'd14;
        if (k == 23) return 6'd4;
        return 6'd0;
      end
      5: begin
        if (k == 1) return 6'd16;
        if (k >= 2 && k <= 4) return alt ? 6'd16 : 6'd32;
        if (k == 5) return 6'd4;
        return 6'd0;
      end
      6: return (k >= 2 && k <= 4) ? 6'd2 : 6'd0;
      default: return 6'd0;
    endcase
  endfunction

  function automatic bit bm_fits(int op, bit alt);
    for (int k = 0; k < TD; k++) begin
      logic [5:0] p, t;
      p = bm_row(op, k, alt);
      t = m_tab[k];
      if ((p & t) != 0) return 0;
      if (p[1] && (t[4] || t[5])) return 0;
      if ((p[4] || p[5]) && t[1]) return 0;
    end
    return 1;
  endfunction

  task automatic chk(bit cond, string tag, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int op, string tag);
    bit g, alt;
    @(negedge clk_i);
    chk(resv_now_o == m_tab[0], tag, "resv_now", resv_now_o, m_tab[0]);
    req_valid_i = v;
    req_op_i = op[2:0];
    alt = !bm_fits(op, 0);
    g = v && (bm_fits(op, 0) || bm_fits(op, 1));
    #1;
    chk(grant_o == g, tag, "grant", grant_o, g);
    chk(busy_o == (v && !g), tag, "busy", busy_o, v && !g);
    @(posedge clk_i);
    for (int k = 0; k < TD; k++)
      m_tab[k] = m_tab[k+1] | (g ? bm_row(op, k + 1, alt) : 6'd0);
    m_tab[TD] = 6'd0;
  endtask

  // present op until granted, as issue logic would
  task automatic issue(int op, string tag);
    bit done = 0;
    while (!done) begin
      done = !busy_expected(op);
      step(1, op, tag);
    end
  endtask

  function automatic bit busy_expected(int op);
    return !(bm_fits(op, 0) || bm_fits(op, 1));
  endfunction

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    for (int k = 0; k <= TD; k++) m_tab[k] = 6'd0;
    seed = 1234;
    void'($urandom(seed));
    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2, "R1");
    // R4: back-to-back single arithmetic both granted
    step(1, 0, "R4"); step(1, 0, "R4"); idle(4, "R4");
    step(1, 2, "R4"); idle(5, "R4");
    // R6 with R3: single arith one cycle after double arith is refused
    step(1, 3, "R6"); step(1, 0, "R3"); idle(9, "R3");
    // R9: multiply behind a status-register load, retried
    step(1, 6, "R10"); issue(5, "R9"); idle(8, "R9");
    // R8: second multiply falls back to MA for its window
    step(1, 5, "R8"); step(1, 5, "R8"); idle(8, "R8");
    // R5, R7, R11
    step(1, 1, "R5"); idle(13, "R5");
    step(1, 4, "R7"); step(1, 7, "R11"); step(1, 4, "R3"); idle(25, "R7");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = ($urandom % 3) != 0;
      step(v, $urandom % 8, "R12");
    end
    idle(26, "R12");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule